// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard logic of a five-stage integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it reads the register fields and control flags of the instructions in decode, execute, memory and writeback. It then chooses, for each execute-stage operand, whether the value comes from the register file, from the result leaving the memory stage, or from the value in writeback. When a load's result is needed by the ALU in the very next instruction, it freezes the front of the pipeline and puts a bubble into execute for one cycle.

A store reads its base register in execute but needs its data register only in the memory stage. So a load followed at once by a store of the loaded register needs no stall. The block registers a late select that steers the writeback-stage load data into the store's memory-stage data path one cycle later. Writeback writes the register file in the first half of a cycle and decode reads it in the second half, so a dependence three instructions apart needs no bypass. The register file, ALU, data memory and branch logic sit outside this block. The only data it handles are register indices, so it has no valid/ready stream interface; every pin is a plain control level.

Top module: `hz_ctrl`

## Requirements
- R1: An execute operand whose source register (non-zero) equals the destination of a valid, register-writing, non-load instruction in the memory stage gets select code 1 (memory-stage result).
- R2: Otherwise, if the source register equals the destination of a valid, register-writing instruction in writeback, the operand gets select code 2 (writeback value); with neither match the code is 0 (register file).
- R3: When the memory and writeback stages both match the same source, the memory stage (the younger producer) wins with code 1.
- R4: Register zero is never bypassed: a source of zero, a producer with write enable low, or a producer with valid low always leaves code 0 for that producer.
- R5: A producer in writeback whose destination equals a decode source raises no stall and changes no select, because the register file's write-before-read covers distance three.
- R6: A valid, register-writing load in execute with a non-zero destination raises a stall when a valid decode instruction reads that register as an ALU operand: its first source, or its second source when decode is not a store.
- R7: During a stall the PC hold, decode hold and execute bubble outputs are all 1 in the same cycle; otherwise all three are 0.
- R8: A store in decode whose second source (data) equals the load's destination in execute does not stall.
- R9: A store in decode whose first source (base address) equals the load's destination in execute does stall.
- R10: A load in the memory stage never supplies an execute operand: the matching operand keeps code 0 or falls to the writeback match.
- R11: When execute holds a valid store whose second source (non-zero) equals the destination of a valid, register-writing load in the memory stage, the store-data select output is 1 in the next cycle (the load then being in writeback and the store in memory); otherwise it is 0.
- R12: After reset the store-data select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the store-data select register |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_valid | input | 1 | Decode-stage instruction is valid |
| d_rs1 | input | AW | Decode first source register |
| d_rs2 | input | AW | Decode second source register |
| d_is_store | input | 1 | Decode instruction is a store |
| x_valid | input | 1 | Execute-stage instruction is valid |
| x_rd | input | AW | Execute destination register |
| x_we | input | 1 | Execute register-write enable |
| x_is_load | input | 1 | Execute instruction is a load |
| x_is_store | input | 1 | Execute instruction is a store |
| x_rs1 | input | AW | Execute first source register |
| x_rs2 | input | AW | Execute second source register |
| m_valid | input | 1 | Memory-stage instruction is valid |
| m_rd | input | AW | Memory-stage destination register |
| m_we | input | 1 | Memory-stage register-write enable |
| m_is_load | input | 1 | Memory-stage instruction is a load |
| w_valid | input | 1 | Writeback instruction is valid |
| w_rd | input | AW | Writeback destination register |
| w_we | input | 1 | Writeback register-write enable |
| fwd_a_sel | output | 2 | First execute operand select (0 file, 1 memory stage, 2 writeback) |
| fwd_b_sel | output | 2 | Second execute operand select, same coding |
| st_data_sel | output | 1 | Memory-stage store data from writeback load value |
| pc_hold | output | 1 | Freeze the PC |
| dec_hold | output | 1 | Freeze the fetch/decode register |
| ex_bubble | output | 1 | Clear all control bits entering execute |

## Verification
The assertions check on every cycle that a memory-stage select always has a real, non-zero, non-load producer behind it, and that a stall always has a load in execute behind it. They also check that a store-data select is always the result of a load/store pairing in the previous cycle, and that the memory stage wins whenever both producers match. Only the bench scenarios can show the actual dependence distances one, two and three. They also show the load-store data case passing through without a stall while the load-store base case stalls, and that the late select lands in exactly the cycle after the pairing.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_REG = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one source index with one producer stage.
module hz_src_match #(
  parameter int unsigned AW = hz_pkg::REG_AW
) (
  input  logic          prod_valid,
  input  logic          prod_we,
  input  logic          prod_block,   // producer may not feed this path
  input  logic [AW-1:0] prod_rd,
  input  logic [AW-1:0] src,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = prod_valid && prod_we && !prod_block &&
          (prod_rd != ZERO_REG) && (prod_rd == src);
  end
endmodule

// File: rtl/hz_operand_sel.sv
// Select for one execute operand; the memory stage has priority.
module hz_operand_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          m_valid,
  input  logic          m_we,
  input  logic          m_is_load,
  input  logic [AW-1:0] m_rd,
  input  logic          w_valid,
  input  logic          w_we,
  input  logic [AW-1:0] w_rd,
  input  logic [AW-1:0] src,
  output fwd_sel_e      sel
);
  logic hit_m, hit_w;

  // A load in memory has no data yet; it never feeds execute.
  hz_src_match #(.AW(AW)) u_mem (
    .prod_valid(m_valid), .prod_we(m_we), .prod_block(m_is_load),
    .prod_rd(m_rd), .src(src), .hit(hit_m)
  );

  hz_src_match #(.AW(AW)) u_wb (
    .prod_valid(w_valid), .prod_we(w_we), .prod_block(1'b0),
    .prod_rd(w_rd), .src(src), .hit(hit_w)
  );

  always_comb begin
    if (hit_m)      sel = FWD_MEM;
    else if (hit_w) sel = FWD_WB;
    else            sel = FWD_REG;
  end
endmodule

// File: rtl/hz_load_use.sv
// Detects an ALU use of a load result one instruction behind the load.
module hz_load_use #(
  parameter int unsigned AW = hz_pkg::REG_AW
) (
  input  logic          d_valid,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_is_store,
  input  logic          x_valid,
  input  logic          x_we,
  input  logic          x_is_load,
  input  logic [AW-1:0] x_rd,
  output logic          stall
);
  logic hit1, hit2;

  hz_src_match #(.AW(AW)) u_rs1 (
    .prod_valid(x_valid && d_valid), .prod_we(x_we), .prod_block(!x_is_load),
    .prod_rd(x_rd), .src(d_rs1), .hit(hit1)
  );

  // Store data is consumed in memory stage, so it is exempt here.
  hz_src_match #(.AW(AW)) u_rs2 (
    .prod_valid(x_valid && d_valid), .prod_we(x_we),
    .prod_block(!x_is_load || d_is_store),
    .prod_rd(x_rd), .src(d_rs2), .hit(hit2)
  );

  always_comb stall = hit1 || hit2;
endmodule

// File: rtl/hz_store_bypass.sv
// Registers the late store-data select one stage ahead of its use.
module hz_store_bypass #(
  parameter int unsigned AW = hz_pkg::REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_valid,
  input  logic          x_is_store,
  input  logic [AW-1:0] x_rs2,
  input  logic          m_valid,
  input  logic          m_we,
  input  logic          m_is_load,
  input  logic [AW-1:0] m_rd,
  output logic          st_data_sel
);
  logic pair_hit;

  hz_src_match #(.AW(AW)) u_pair (
    .prod_valid(m_valid && x_valid && x_is_store), .prod_we(m_we),
    .prod_block(!m_is_load), .prod_rd(m_rd), .src(x_rs2), .hit(pair_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_data_sel <= 1'b0;
    else        st_data_sel <= pair_hit;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_valid,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_is_store,
  input  logic          x_valid,
  input  logic [AW-1:0] x_rd,
  input  logic          x_we,
  input  logic          x_is_load,
  input  logic          x_is_store,
  input  logic [AW-1:0] x_rs1,
  input  logic [AW-1:0] x_rs2,
  input  logic          m_valid,
  input  logic [AW-1:0] m_rd,
  input  logic          m_we,
  input  logic          m_is_load,
  input  logic          w_valid,
  input  logic [AW-1:0] w_rd,
  input  logic          w_we,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          st_data_sel,
  output logic          pc_hold,
  output logic          dec_hold,
  output logic          ex_bubble
);
  localparam int unsigned N_OPS = 2;

  logic [AW-1:0] x_src [N_OPS];
  fwd_sel_e      op_sel [N_OPS];
  logic          stall;

  assign x_src[0] = x_rs1;
  assign x_src[1] = x_rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_operand_sel #(.AW(AW)) u_sel (
      .m_valid(m_valid), .m_we(m_we), .m_is_load(m_is_load), .m_rd(m_rd),
      .w_valid(w_valid), .w_we(w_we), .w_rd(w_rd),
      .src(x_src[g]), .sel(op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  hz_load_use #(.AW(AW)) u_lu (
    .d_valid(d_valid), .d_rs1(d_rs1), .d_rs2(d_rs2), .d_is_store(d_is_store),
    .x_valid(x_valid), .x_we(x_we), .x_is_load(x_is_load), .x_rd(x_rd),
    .stall(stall)
  );

  assign pc_hold   = stall;
  assign dec_hold  = stall;
  assign ex_bubble = stall;

  hz_store_bypass #(.AW(AW)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .x_valid(x_valid), .x_is_store(x_is_store), .x_rs2(x_rs2),
    .m_valid(m_valid), .m_we(m_we), .m_is_load(m_is_load), .m_rd(m_rd),
    .st_data_sel(st_data_sel)
  );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int unsigned AW = hz_pkg::REG_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          x_valid,
  input logic          x_is_load,
  input logic          x_is_store,
  input logic          x_we,
  input logic [AW-1:0] x_rs1,
  input logic [AW-1:0] x_rs2,
  input logic          m_valid,
  input logic          m_we,
  input logic          m_is_load,
  input logic [AW-1:0] m_rd,
  input logic          w_valid,
  input logic          w_we,
  input logic [AW-1:0] w_rd,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic          st_data_sel,
  input logic          pc_hold
);
  // R1
  mem_src_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a_sel == 2'd1 |-> m_valid && m_we && !m_is_load && m_rd == x_rs1);

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rs1 == '0) |-> fwd_a_sel == 2'd0);

  // R3
  young_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_we && !m_is_load && m_rd != '0 && m_rd == x_rs2 &&
     w_valid && w_we && w_rd == x_rs2) |-> fwd_b_sel == 2'd1);

  // R10
  no_load_mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_is_load |-> (fwd_a_sel != 2'd1 && fwd_b_sel != 2'd1));

  // R6
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> x_valid && x_is_load && x_we);

  // R11
  st_sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_sel |-> $past(x_valid && x_is_store && m_valid && m_is_load && m_we &&
                          m_rd == x_rs2));
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .x_valid(x_valid), .x_is_load(x_is_load), .x_is_store(x_is_store), .x_we(x_we),
  .x_rs1(x_rs1), .x_rs2(x_rs2),
  .m_valid(m_valid), .m_we(m_we), .m_is_load(m_is_load), .m_rd(m_rd),
  .w_valid(w_valid), .w_we(w_we), .w_rd(w_rd),
  .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
  .st_data_sel(st_data_sel), .pc_hold(pc_hold)
);

// File: tb/hz_ctrl_test.sv
module hz_ctrl_test;
  localparam int unsigned AW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d_valid, d_is_store, x_valid, x_we, x_is_load, x_is_store;
  logic m_valid, m_we, m_is_load, w_valid, w_we;
  logic [AW-1:0] d_rs1, d_rs2, x_rd, x_rs1, x_rs2, m_rd, w_rd;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic st_data_sel, pc_hold, dec_hold, ex_bubble;

  int total = 0, bad = 0;
  logic exp_st_q = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_ctrl #(.AW(AW)) uut (.*);

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    if (s != 0 && m_valid && m_we && !m_is_load && m_rd == s) return 2'd1;
    if (s != 0 && w_valid && w_we && w_rd == s) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic exp_stall();
    return x_valid && x_is_load && x_we && x_rd != 0 && d_valid &&
           (d_rs1 == x_rd || (!d_is_store && d_rs2 == x_rd));
  endfunction

  function automatic logic exp_st_next();
    return x_valid && x_is_store && m_valid && m_is_load && m_we &&
           m_rd != 0 && m_rd == x_rs2;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {d_valid, d_is_store, x_valid, x_we, x_is_load, x_is_store} = '0;
    {m_valid, m_we, m_is_load, w_valid, w_we} = '0;
    {d_rs1, d_rs2, x_rd, x_rs1, x_rs2, m_rd, w_rd} = '0;
  endtask

  // Drive at negedge after checking the registered select, then check comb outputs.
  task automatic step_begin();
    @(negedge clk);
    chk("R11 st_data_sel", {3'b0, st_data_sel}, {3'b0, exp_st_q});
  endtask

  task automatic step_end(input string tag_a, input string tag_b, input string tag_s);
    #1;
    chk(tag_a, {2'b0, fwd_a_sel}, {2'b0, exp_sel(x_rs1)});
    chk(tag_b, {2'b0, fwd_b_sel}, {2'b0, exp_sel(x_rs2)});
    chk(tag_s, {3'b0, pc_hold}, {3'b0, exp_stall()});
    chk("R7 holds agree", {1'b0, pc_hold, dec_hold, ex_bubble},
        {1'b0, {3{exp_stall()}}});
    exp_st_q = exp_st_next();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    #(CLK_PERIOD * 2);
    #1;
    chk("R12 reset st_data_sel", {3'b0, st_data_sel}, 4'd0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R12 after release", {3'b0, st_data_sel}, 4'd0);

    // R1 distance one ALU producer
    step_begin(); idle();
    m_valid = 1; m_we = 1; m_rd = 5'd7; x_valid = 1; x_rs1 = 5'd7; x_rs2 = 5'd3;
    step_end("R1 dist1 a", "R1 dist1 b", "R1 no stall");
    chk("R1 code", {2'b0, fwd_a_sel}, 4'd1);

    // R2 distance two
    step_begin(); idle();
    w_valid = 1; w_we = 1; w_rd = 5'd9; x_valid = 1; x_rs2 = 5'd9;
    step_end("R2 dist2 a", "R2 dist2 b", "R2 no stall");
    chk("R2 code", {2'b0, fwd_b_sel}, 4'd2);

    // R3 both stages match
    step_begin(); idle();
    m_valid = 1; m_we = 1; m_rd = 5'd4; w_valid = 1; w_we = 1; w_rd = 5'd4;
    x_valid = 1; x_rs1 = 5'd4; x_rs2 = 5'd4;
    step_end("R3 a", "R3 b", "R3 stall");
    chk("R3 code", {2'b0, fwd_a_sel}, 4'd1);

    // R4 zero register and disabled producers
    step_begin(); idle();
    m_valid = 1; m_we = 1; m_rd = 5'd0; x_valid = 1; x_rs1 = 5'd0;
    w_valid = 1; w_we = 0; w_rd = 5'd6; x_rs2 = 5'd6;
    step_end("R4 zero a", "R4 we low b", "R4 stall");
    chk("R4 code", {fwd_a_sel, fwd_b_sel}, 4'd0);

    // R5 distance three: writeback vs decode
    step_begin(); idle();
    w_valid = 1; w_we = 1; w_rd = 5'd12; d_valid = 1; d_rs1 = 5'd12; d_rs2 = 5'd12;
    step_end("R5 a", "R5 b", "R5 no stall");
    chk("R5 stall", {3'b0, pc_hold}, 4'd0);

    // R6 load-use on second ALU source
    step_begin(); idle();
    x_valid = 1; x_is_load = 1; x_we = 1; x_rd = 5'd8; d_valid = 1; d_rs2 = 5'd8;
    step_end("R6 a", "R6 b", "R6 stall");
    chk("R6 stall", {3'b0, pc_hold}, 4'd1);

    // R9 load then store using it as base
    step_begin(); idle();
    x_valid = 1; x_is_load = 1; x_we = 1; x_rd = 5'd10;
    d_valid = 1; d_is_store = 1; d_rs1 = 5'd10; d_rs2 = 5'd2;
    step_end("R9 a", "R9 b", "R9 stall");
    chk("R9 stall", {3'b0, ex_bubble}, 4'd1);

    // R8 load then store of loaded data: no stall
    step_begin(); idle();
    x_valid = 1; x_is_load = 1; x_we = 1; x_rd = 5'd11;
    d_valid = 1; d_is_store = 1; d_rs1 = 5'd2; d_rs2 = 5'd11;
    step_end("R8 a", "R8 b", "R8 no stall");
    chk("R8 stall", {3'b0, pc_hold}, 4'd0);

    // Next cycle: the pair moves to memory/execute; R10 and R11
    step_begin(); idle();
    m_valid = 1; m_is_load = 1; m_we = 1; m_rd = 5'd11;
    x_valid = 1; x_is_store = 1; x_rs1 = 5'd2; x_rs2 = 5'd11;
    step_end("R10 a", "R10 b", "R10 stall");
    chk("R10 b code", {2'b0, fwd_b_sel}, 4'd0);
    step_begin(); idle();
    chk("R11 late select", {3'b0, st_data_sel}, 4'd1);
    step_end("R11 a", "R11 b", "R11 stall");

    // Constrained random: small register range for frequent matches
    for (int i = 0; i < 3000; i++) begin
      step_begin();
      d_valid = 1'($urandom); d_is_store = ($urandom % 4) == 0;
      d_rs1 = AW'($urandom % 4); d_rs2 = AW'($urandom % 4);
      x_valid = 1'($urandom); x_is_load = ($urandom % 3) == 0;
      x_is_store = !x_is_load && (($urandom % 3) == 0);
      x_we = !x_is_store && (($urandom % 5) != 0);
      x_rd = AW'($urandom % 4); x_rs1 = AW'($urandom % 4); x_rs2 = AW'($urandom % 4);
      m_valid = 1'($urandom); m_is_load = ($urandom % 3) == 0;
      m_we = ($urandom % 5) != 0; m_rd = AW'($urandom % 4);
      w_valid = 1'($urandom); w_we = ($urandom % 5) != 0; w_rd = AW'($urandom % 4);
      step_end("R1 rand a", "R2 rand b", "R6 rand stall");
    end

    step_begin();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule